// File: doc/BRIEF.md
# Multi-cycle Unit Issue Interlock

This block sits in the decode stage of an in-order pipeline. Behind it are execution units with different latencies: an integer ALU, a memory unit, a floating-point adder, a floating-point multiplier and an unpipelined floating-point divider. For each decoded instruction it receives the target unit, up to two source register specifiers, an optional destination specifier and a valid bit. It raises `stall` whenever issuing the instruction in the current cycle would be unsafe, and it records the instruction's effects only in a cycle where the instruction actually issues (`id_valid` high and `stall` low).

Three pieces of state drive the decision. The first is a shift register that books the single write-back port: one bit per future cycle, shifted every clock. The second is a pair of pending-destination vectors, one for the integer register file and one for the floating-point register file. The third is a busy counter for the divider. Write-back notifications on the `wb_*` inputs clear pending flags, and the clear is visible to the decode check in the same cycle. The asynchronous active-low reset is released through a two-flop synchronizer.

Top module: `issue_interlock`

## Requirements
- R1: After reset, every reservation, every pending flag and the divider counter are clear. A valid instruction that arrives after reset is therefore issued without a stall, even if it names registers that were pending before reset.
- R2: Unit codes on `id_unit` are 0 integer ALU, 1 memory, 2 FP adder, 3 FP multiplier and 4 FP divider. Their execution latencies are 0, 1, 3, 6 and 24. An instruction issued in cycle t writes back in cycle t + latency + 3, which is t+3, t+4, t+6, t+9 or t+27.
- R3: An instruction with a destination stalls if its write-back cycle is already booked. A stalled instruction books nothing.
- R4: Once a divide issues, any further divide stalls for the next 24 cycles. A divide can issue again 25 cycles after the previous one.
- R5: An instruction stalls if an enabled source names a register whose pending flag is set in the file that `id_srcN_fp` selects (0 integer, 1 FP).
- R6: An instruction stalls if its destination is already pending in the file that `id_dst_fp` selects.
- R7: A write-back (`wb_valid`, `wb_fp`, `wb_dst`) clears that register's pending flag, and the decode check in the same cycle already sees the flag as clear.
- R8: An instruction without a destination (`id_dst_en` low), such as a store or a branch, books no write-back slot and sets no pending flag.
- R9: The integer and FP pending vectors are independent. A register number pending in one file does not stall an access to the same number in the other file.
- R10: A stalled instruction changes no pending flag, no slot booking and no divider state. Only the shift of the slot register and the countdown of the divider counter go on.
- R11: When `id_valid` is low, `stall` is low and nothing is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode slot holds an instruction |
| id_unit | input | 3 | Target unit code (see R2) |
| id_src1_en | input | 1 | First source is used |
| id_src1_fp | input | 1 | First source file: 0 integer, 1 FP |
| id_src1 | input | RW (5) | First source register number |
| id_src2_en | input | 1 | Second source is used |
| id_src2_fp | input | 1 | Second source file: 0 integer, 1 FP |
| id_src2 | input | RW (5) | Second source register number |
| id_dst_en | input | 1 | Instruction writes a register |
| id_dst_fp | input | 1 | Destination file: 0 integer, 1 FP |
| id_dst | input | RW (5) | Destination register number |
| wb_valid | input | 1 | A register is written back this cycle |
| wb_fp | input | 1 | File of the written-back register |
| wb_dst | input | RW (5) | Number of the written-back register |
| stall | output | 1 | Hold the decoded instruction this cycle |

## Verification
The assertions assume that `id_unit` carries only the five defined codes. They also assume that the `wb_*` inputs report only registers that the pipeline considers in flight, because the interlock does not cross-check write-back timing against its own slot bookings. The stimulus keeps to these assumptions: it uses only the five unit codes, and it raises write-back notifications only for registers it issued earlier. Stalled instructions are presented again in later cycles, which is how a real decode stage behaves.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  typedef enum logic [2:0] {
    U_INT  = 3'd0,
    U_MEM  = 3'd1,
    U_FADD = 3'd2,
    U_FMUL = 3'd3,
    U_FDIV = 3'd4
  } unit_e;

  localparam int unsigned LAT_INT  = 0;
  localparam int unsigned LAT_MEM  = 1;
  localparam int unsigned LAT_FADD = 3;
  localparam int unsigned LAT_FMUL = 6;
  localparam int unsigned LAT_FDIV = 24;
  // cycles from decode to write-back beyond the unit's own latency
  localparam int unsigned PIPE_GAP = 3;
  localparam int unsigned DIV_II   = 25;
  localparam int unsigned SLOT_W   = LAT_FDIV + PIPE_GAP + 1;

  function automatic int unsigned wb_off(logic [2:0] u);
    case (u)
      U_MEM:   return LAT_MEM  + PIPE_GAP;
      U_FADD:  return LAT_FADD + PIPE_GAP;
      U_FMUL:  return LAT_FMUL + PIPE_GAP;
      U_FDIV:  return LAT_FDIV + PIPE_GAP;
      default: return LAT_INT  + PIPE_GAP;
    endcase
  endfunction
endpackage

// File: rtl/wb_slot_tracker.sv
module wb_slot_tracker #(
  parameter int W  = 28,
  parameter int OW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          claim,
  input  logic [OW-1:0] off,
  output logic          busy,
  output logic [W-1:0]  slots
);
  logic [W-1:0] slots_q, slots_d;

  // bit k of slots_q: the port is booked k cycles from now
  always_comb begin
    slots_d = slots_q >> 1;
    if (claim) slots_d[off - OW'(1)] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slots_q <= '0;
    else        slots_q <= slots_d;
  end

  assign busy  = slots_q[off];
  assign slots = slots_q;
endmodule

// File: rtl/pend_scoreboard.sv
module pend_scoreboard #(
  parameter int NREG = 32,
  parameter int RW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_en,
  input  logic [RW-1:0]   clr_idx,
  input  logic            set_en,
  input  logic [RW-1:0]   set_idx,
  input  logic [RW-1:0]   q1_idx,
  input  logic [RW-1:0]   q2_idx,
  input  logic [RW-1:0]   q3_idx,
  output logic            hit1,
  output logic            hit2,
  output logic            hit3,
  output logic [NREG-1:0] flags
);
  logic [NREG-1:0] flags_q, flags_d, eff, clr_mask, set_mask;
  logic            en;

  always_comb begin
    clr_mask = clr_en ? (NREG'(1) << clr_idx) : '0;
    set_mask = set_en ? (NREG'(1) << set_idx) : '0;
    eff      = flags_q & ~clr_mask;   // write-back clear visible this cycle
    flags_d  = eff | set_mask;
    en       = clr_en | set_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  flags_q <= '0;
    else if (en) flags_q <= flags_d;
  end

  assign hit1  = eff[q1_idx];
  assign hit2  = eff[q2_idx];
  assign hit3  = eff[q3_idx];
  assign flags = flags_q;
endmodule

// File: rtl/div_busy_ctr.sv
module div_busy_ctr #(
  parameter int II = 25,
  parameter int CW = $clog2(II)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  always_comb begin
    busy  = (cnt_q != '0);
    en    = start | busy;
    cnt_d = start ? CW'(II - 1) : cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import ilk_pkg::*;
#(
  parameter  int NREG = 32,
  localparam int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          id_valid,
  input  logic [2:0]    id_unit,
  input  logic          id_src1_en,
  input  logic          id_src1_fp,
  input  logic [RW-1:0] id_src1,
  input  logic          id_src2_en,
  input  logic          id_src2_fp,
  input  logic [RW-1:0] id_src2,
  input  logic          id_dst_en,
  input  logic          id_dst_fp,
  input  logic [RW-1:0] id_dst,
  input  logic          wb_valid,
  input  logic          wb_fp,
  input  logic [RW-1:0] wb_dst,
  output logic          stall
);
  localparam int OW = $clog2(SLOT_W);

  // asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic [OW-1:0]     off_c;
  logic              issue, is_div, slot_busy, div_busy;
  logic [1:0]        h1, h2, h3;
  logic [NREG-1:0]   flags [2];
  logic [NREG-1:0]   int_flags, fp_flags;
  logic [SLOT_W-1:0] slot_vec;
  logic              src1_hit, src2_hit, dst_hit;

  assign off_c  = OW'(wb_off(id_unit));
  assign is_div = (id_unit == U_FDIV);

  for (genvar f = 0; f < 2; f++) begin : g_file
    pend_scoreboard #(.NREG(NREG), .RW(RW)) u_sb (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .clr_en  (wb_valid && (wb_fp == (f != 0))),
      .clr_idx (wb_dst),
      .set_en  (issue && id_dst_en && (id_dst_fp == (f != 0))),
      .set_idx (id_dst),
      .q1_idx  (id_src1),
      .q2_idx  (id_src2),
      .q3_idx  (id_dst),
      .hit1    (h1[f]),
      .hit2    (h2[f]),
      .hit3    (h3[f]),
      .flags   (flags[f])
    );
  end

  assign int_flags = flags[0];
  assign fp_flags  = flags[1];

  wb_slot_tracker #(.W(SLOT_W), .OW(OW)) u_slots (
    .clk   (clk),
    .rst_n (rst_int_n),
    .claim (issue && id_dst_en),
    .off   (off_c),
    .busy  (slot_busy),
    .slots (slot_vec)
  );

  div_busy_ctr #(.II(DIV_II)) u_div (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (issue && is_div),
    .busy  (div_busy)
  );

  always_comb begin
    src1_hit = id_src1_en && (id_src1_fp ? h1[1] : h1[0]);
    src2_hit = id_src2_en && (id_src2_fp ? h2[1] : h2[0]);
    dst_hit  = id_dst_en  && (id_dst_fp  ? h3[1] : h3[0]);
    stall    = id_valid && (src1_hit || src2_hit || dst_hit ||
                            (id_dst_en && slot_busy) || (is_div && div_busy));
    issue    = id_valid && !stall;
  end
endmodule

// File: rtl/issue_interlock_chk.sv
module issue_interlock_chk
  import ilk_pkg::*;
#(
  parameter int NREG = 32,
  parameter int RW   = $clog2(NREG)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              id_valid,
  input logic [2:0]        id_unit,
  input logic              id_dst_en,
  input logic              id_dst_fp,
  input logic [RW-1:0]     id_dst,
  input logic              wb_valid,
  input logic              wb_fp,
  input logic [RW-1:0]     wb_dst,
  input logic              stall,
  input logic [SLOT_W-1:0] slot_vec,
  input logic [NREG-1:0]   int_flags
);
  localparam int OW = $clog2(SLOT_W);
  logic [OW-1:0] off_c;
  logic          iss;
  assign off_c = OW'(wb_off(id_unit));
  assign iss   = id_valid && !stall;

  AST_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss && id_dst_en) |-> !slot_vec[off_c]); // R3

  AST_SLOT_BOOKED: assert property (@(posedge clk) disable iff (!rst_n)
    (iss && id_dst_en) |=> slot_vec[$past(off_c) - OW'(1)]); // R2

  AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (iss && id_unit == U_FDIV) |=> !(id_valid && id_unit == U_FDIV && !stall)); // R4

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (iss && id_dst_en && !id_dst_fp) |=> int_flags[$past(id_dst)]); // R5

  AST_WAW_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && id_dst_en && !id_dst_fp && int_flags[id_dst] &&
     !(wb_valid && !wb_fp && wb_dst == id_dst)) |-> stall); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> !stall); // R11
endmodule

bind issue_interlock issue_interlock_chk #(.NREG(NREG), .RW(RW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .id_valid  (id_valid),
  .id_unit   (id_unit),
  .id_dst_en (id_dst_en),
  .id_dst_fp (id_dst_fp),
  .id_dst    (id_dst),
  .wb_valid  (wb_valid),
  .wb_fp     (wb_fp),
  .wb_dst    (wb_dst),
  .stall     (stall),
  .slot_vec  (slot_vec),
  .int_flags (int_flags)
);

// File: tb/test_issue_interlock.sv
`timescale 1ns/1ps
module test_issue_interlock;
  localparam int CLK_NS = 8;

  typedef struct packed {
    logic       v;
    logic [2:0] u;
    logic       s1e, s1f;
    logic [4:0] s1;
    logic       s2e, s2f;
    logic [4:0] s2;
    logic       de, df;
    logic [4:0] d;
    logic       wv, wf;
    logic [4:0] wd;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  // fields: v u | s1e s1f s1 | s2e s2f s2 | de df d | wv wf wd | exp req
  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b1,3'd0, 1'b1,1'b0,5'd2, 1'b0,1'b0,5'd0, 1'b1,1'b0,5'd1, 1'b0,1'b0,5'd0, 1'b0,4'd1},  // R1 first issue
    '{1'b1,3'd0, 1'b1,1'b0,5'd1, 1'b0,1'b0,5'd0, 1'b1,1'b0,5'd3, 1'b0,1'b0,5'd0, 1'b1,4'd5},  // R5 read pending r1
    '{1'b1,3'd2, 1'b1,1'b1,5'd1, 1'b0,1'b0,5'd0, 1'b1,1'b1,5'd2, 1'b0,1'b0,5'd0, 1'b0,4'd9},  // R9 f1 vs r1
    '{1'b1,3'd0, 1'b1,1'b0,5'd1, 1'b0,1'b0,5'd0, 1'b1,1'b0,5'd4, 1'b1,1'b0,5'd1, 1'b0,4'd7},  // R7 same-cycle clear
    '{1'b1,3'd3, 1'b0,1'b0,5'd0, 1'b0,1'b0,5'd0, 1'b1,1'b1,5'd2, 1'b0,1'b0,5'd0, 1'b1,4'd6},  // R6 dst f2 pending
    '{1'b1,3'd0, 1'b0,1'b0,5'd0, 1'b0,1'b0,5'd0, 1'b1,1'b0,5'd5, 1'b0,1'b0,5'd0, 1'b1,4'd3},  // R3 slot of FADD
    '{1'b1,3'd0, 1'b0,1'b0,5'd0, 1'b0,1'b0,5'd0, 1'b1,1'b0,5'd5, 1'b0,1'b0,5'd0, 1'b0,4'd10}, // R10 r5 not set by stall
    '{1'b1,3'd1, 1'b1,1'b0,5'd2, 1'b1,1'b1,5'd4, 1'b0,1'b0,5'd0, 1'b0,1'b0,5'd0, 1'b0,4'd8},  // R8 store
    '{1'b1,3'd0, 1'b0,1'b0,5'd0, 1'b0,1'b0,5'd0, 1'b1,1'b0,5'd7, 1'b1,1'b1,5'd2, 1'b0,4'd8},  // R8 store left slot free
    '{1'b1,3'd4, 1'b1,1'b1,5'd2, 1'b0,1'b0,5'd0, 1'b1,1'b1,5'd5, 1'b0,1'b0,5'd0, 1'b0,4'd7},  // R7 f2 cleared
    '{1'b1,3'd4, 1'b0,1'b0,5'd0, 1'b0,1'b0,5'd0, 1'b1,1'b1,5'd6, 1'b0,1'b0,5'd0, 1'b1,4'd4},  // R4 divider busy
    '{1'b0,3'd0, 1'b1,1'b0,5'd5, 1'b0,1'b0,5'd0, 1'b1,1'b0,5'd8, 1'b0,1'b0,5'd0, 1'b0,4'd11}  // R11 invalid slot
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       id_valid, id_src1_en, id_src1_fp, id_src2_en, id_src2_fp;
  logic       id_dst_en, id_dst_fp, wb_valid, wb_fp, stall;
  logic [2:0] id_unit;
  logic [4:0] id_src1, id_src2, id_dst, wb_dst;
  int         n_chk = 0;
  int         n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  issue_interlock i_issue_interlock (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_unit(id_unit),
    .id_src1_en(id_src1_en), .id_src1_fp(id_src1_fp), .id_src1(id_src1),
    .id_src2_en(id_src2_en), .id_src2_fp(id_src2_fp), .id_src2(id_src2),
    .id_dst_en(id_dst_en), .id_dst_fp(id_dst_fp), .id_dst(id_dst),
    .wb_valid(wb_valid), .wb_fp(wb_fp), .wb_dst(wb_dst), .stall(stall)
  );

  function automatic vec_t mk(logic [2:0] u, logic de, logic df, logic [4:0] d,
                              logic exp, logic [3:0] req);
    vec_t x = '0;
    x.v = 1'b1; x.u = u; x.de = de; x.df = df; x.d = d;
    x.exp = exp; x.req = req;
    return x;
  endfunction

  task automatic drive(vec_t x);
    id_valid = x.v;   id_unit = x.u;
    id_src1_en = x.s1e; id_src1_fp = x.s1f; id_src1 = x.s1;
    id_src2_en = x.s2e; id_src2_fp = x.s2f; id_src2 = x.s2;
    id_dst_en = x.de; id_dst_fp = x.df; id_dst = x.d;
    wb_valid = x.wv; wb_fp = x.wf; wb_dst = x.wd;
  endtask

  task automatic apply(vec_t x);
    @(negedge clk);
    drive(x);
    #1;
    n_chk++;
    if (stall !== x.exp) begin
      n_fail++;
      $display("FAIL R%0d: stall=%0b expected %0b", x.req, stall, x.exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      drive('0);
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL R1: watchdog expired, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    drive('0);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    for (int k = 0; k < NV; k++) apply(TBL[k]);   // table walk, cycles c0..c11

    idle(21);                                      // c12..c32
    apply(mk(3'd4, 1'b1, 1'b1, 5'd6, 1'b1, 4'd4)); // R4 24 cycles after divide
    apply(mk(3'd4, 1'b1, 1'b1, 5'd6, 1'b0, 4'd4)); // R4 25 cycles after divide

    // R1: reset mid-run clears r5 pending and divider busy
    @(negedge clk); drive('0); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    begin
      vec_t x = mk(3'd0, 1'b1, 1'b0, 5'd8, 1'b0, 4'd1);
      x.s1e = 1'b1; x.s1 = 5'd5;
      apply(x);                                    // R1 r5 no longer pending
    end
    apply(mk(3'd4, 1'b1, 1'b1, 5'd9, 1'b0, 4'd1)); // R1 divide free; cycle a
    idle(16);
    apply(mk(3'd3, 1'b1, 1'b1, 5'd1, 1'b0, 4'd2)); // R2 FMUL a+17 -> a+26
    apply(mk(3'd3, 1'b1, 1'b1, 5'd2, 1'b1, 4'd2)); // R2 FMUL a+18 -> a+27
    idle(2);
    apply(mk(3'd2, 1'b1, 1'b1, 5'd3, 1'b1, 4'd2)); // R2 FADD a+21 -> a+27
    idle(1);
    apply(mk(3'd1, 1'b1, 1'b1, 5'd4, 1'b1, 4'd2)); // R2 MEM a+23 -> a+27
    apply(mk(3'd0, 1'b1, 1'b0, 5'd1, 1'b1, 4'd2)); // R2 INT a+24 -> a+27
    apply(mk(3'd0, 1'b1, 1'b0, 5'd2, 1'b0, 4'd2)); // R2 INT a+25 -> a+28
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule